// File: doc/BRIEF.md
# Stacked Monitor Chain Sequencer

This block is the SPI master for a daisy chain of up to eight stacked cell-monitor devices that talk in 32-bit frames. After reset it finds out how many devices are in the chain on its own. It puts every part into readback mode with a software reset, then polls frames until the chain answers with an all-zero word. Each answering device must report its own position in the chain. The device address is carried least significant bit first, so the sequencer reverses the 5-bit address field before comparing it with the frame index.

On a start request the block runs a scan. It selects channel 0 on all parts and starts a conversion through chip select. It then waits a time worked out from the acquisition-time setting, the averaging setting and the chain length. After the wait it polls one frame for each channel of each device. Every frame that arrives is passed out on a one-cycle stream. The 12-bit readings of the cell channels are added into a running sum.

The CRC arithmetic sits outside the block. The sequencer presents a 22-bit message on a registered port. The companion calculator returns the 8-bit CRC one cycle later. That value is inserted into outgoing command frames and compared against the CRC field of incoming frames.

Top module: `chain_seq`

## Requirements
- R1: While reset is held, cs_n is 1, sclk is 0, and busy, done, all error flags, slave_cnt and sum are 0.
- R2: Enumeration sends three broadcast writes to device address 0, each with the all-parts bit 12 set. The frame layout is: device address in bits 31:27, register in 26:21, data in 20:13, CRC in 10:3, and bits 2:0 = 010. The three writes, in order, are: register 0x0E with data {1, acq_sel, 10101b}; register 0x0E with data {0, acq_sel, 10101b}; register 0x1C with data 0x38.
- R3: During enumeration, frame number k (counting from 0) ends the count when it is all zero. slave_cnt then becomes k-1 and no further frame is sent.
- R4: During enumeration, a non-zero frame whose bit-reversed bits 31:27 differ from its index sets err_addr and ends the sequence.
- R5: err_count is set if the first polled frame is all zero, or if nine non-zero valid frames arrive.
- R6: A scan first writes register 0x1C with data 0x00, then register 0x0D with data {0000b, 1, avg_sel, 0}.
- R7: Every polled frame transmits 0xF800030A.
- R8: Between the end of the second scan write and the first poll, the wait is ceil(((t+695)·12·2^avg_sel − t + 250·slave_cnt)/1000)+5 µs. Here t is 465, 1010, 1460 or 1890 ns for acq_sel = 0..3.
- R9: A scan polls (slave_cnt+1)·12 frames and emits each one unchanged on frm_data with a one-cycle frm_valid.
- R10: sum is the total of bits 22:11 over the scan frames whose channel code in bits 26:23 is at most 5.
- R11: A frame whose bits 9:2 differ from the CRC of bits 31:10 sets err_crc. The sequence then ends, with done on the following cycle.
- R12: SPI runs in mode 1 (sclk idle low, data launched on the rising edge and sampled on the falling edge). cs_n stays high for at least one sclk period between frames.
- R13: A start pulse while busy is high has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset; enumeration follows it |
| start | input | 1 | Request a scan when idle |
| acq_sel | input | 2 | Acquisition-time setting, captured at sequence start |
| avg_sel | input | 2 | Averaging setting (2^avg_sel samples), captured at scan start |
| busy | output | 1 | A sequence is running |
| done | output | 1 | One-cycle pulse at the end of a sequence |
| slave_cnt | output | 3 | Chain members beyond the first |
| frm_valid | output | 1 | Scan frame strobe |
| frm_data | output | 32 | Received scan frame |
| sum | output | 32 | Sum of cell readings of the last scan |
| err_crc | output | 1 | Received CRC mismatch |
| err_addr | output | 1 | Enumeration address mismatch |
| err_count | output | 1 | Chain empty or too long |
| crc_msg | output | 22 | Message to the CRC calculator |
| crc_val | input | 8 | CRC of crc_msg, valid the cycle after it changes |
| sclk | output | 1 | SPI clock |
| mosi | output | 1 | SPI data out |
| miso | input | 1 | SPI data in |
| cs_n | output | 1 | SPI chip select, active low |

## Verification
The bench models the chain as an SPI slave that replays prepared frames and records every frame the master sends. Several corner cases get their own stimulus:
- A chain of the maximum length, where an off-by-one in the count gives the wrong slave_cnt or runs one frame too many.
- Nine non-zero frames and an immediately empty chain, both of which must raise err_count rather than hang or report a count.
- A misaddressed second device, which catches a design that compares the address without reversing its bits.
- A corrupted CRC in the middle of a scan, which must stop polling at once and not emit that frame.

Random acquisition and averaging settings measure the conversion wait against the formula. A design that drops the 5 µs margin or the chain-length term falls outside the allowed window. Auxiliary channels carry large values, so summing them shows up in sum.

// File: rtl/chain_seq_pkg.sv
package chain_seq_pkg;

  localparam logic [5:0]  RA_CTL_HI = 6'h0D;
  localparam logic [5:0]  RA_CTL_LO = 6'h0E;
  localparam logic [5:0]  RA_RD_SEL = 6'h1C;
  localparam logic [31:0] POLL_WORD = 32'hF800030A;

  typedef enum logic [3:0] {
    S_IDLE, S_HDR, S_WLOAD, S_WXFER, S_DELAY, S_POLL, S_RXFER, S_EVAL, S_FIN
  } seq_state_t;

  typedef enum logic { M_ENUM, M_SCAN } seq_mode_t;

  // acquisition time in ns for each setting
  function automatic logic [10:0] acq_ns(input logic [1:0] sel);
    case (sel)
      2'd0:    return 11'd465;
      2'd1:    return 11'd1010;
      2'd2:    return 11'd1460;
      default: return 11'd1890;
    endcase
  endfunction

  function automatic logic [4:0] rev5(input logic [4:0] a);
    logic [4:0] r;
    for (int i = 0; i < 5; i++) r[i] = a[4-i];
    return r;
  endfunction

  // upper 21 bits of a broadcast write to the chain head
  function automatic logic [20:0] cmd_hdr(input logic [5:0] ra, input logic [7:0] val);
    return {5'd0, ra, val, 1'b1, 1'b0};
  endfunction

endpackage

// File: rtl/chain_spi_phy.sv
module chain_spi_phy #(
  parameter int HALF = 30
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        start,
  input  logic [31:0] tx_word,
  input  logic        miso,
  output logic        sclk,
  output logic        mosi,
  output logic        cs_n,
  output logic        done,
  output logic [31:0] rx_word
);
  localparam int TW = $clog2(2*HALF + 1);

  typedef enum logic [2:0] { P_IDLE, P_LEAD, P_SHIFT, P_TRAIL, P_GAP } phy_state_t;

  phy_state_t    st;
  logic [TW-1:0] tick;
  logic [4:0]    bitn;
  logic [31:0]   sh;

  always_ff @(posedge clk) begin
    done <= 1'b0;
    if (rst) begin
      st      <= P_IDLE;
      tick    <= '0;
      bitn    <= '0;
      sh      <= '0;
      rx_word <= '0;
      sclk    <= 1'b0;
      mosi    <= 1'b0;
      cs_n    <= 1'b1;
    end else begin
      case (st)
        P_IDLE: if (start) begin
          sh   <= tx_word;
          cs_n <= 1'b0;
          tick <= TW'(HALF - 1);
          st   <= P_LEAD;
        end
        P_LEAD: if (tick == '0) begin
          sclk <= 1'b1;
          mosi <= sh[31];
          sh   <= {sh[30:0], 1'b0};
          bitn <= '0;
          tick <= TW'(HALF - 1);
          st   <= P_SHIFT;
        end else tick <= tick - 1'b1;
        P_SHIFT: if (tick == '0) begin
          tick <= TW'(HALF - 1);
          if (sclk) begin
            sclk    <= 1'b0;
            rx_word <= {rx_word[30:0], miso};
            if (bitn == 5'd31) st <= P_TRAIL;
            else bitn <= bitn + 1'b1;
          end else begin
            sclk <= 1'b1;
            mosi <= sh[31];
            sh   <= {sh[30:0], 1'b0};
          end
        end else tick <= tick - 1'b1;
        P_TRAIL: if (tick == '0) begin
          cs_n <= 1'b1;
          mosi <= 1'b0;
          tick <= TW'(2*HALF - 1);
          st   <= P_GAP;
        end else tick <= tick - 1'b1;
        P_GAP: if (tick == '0) begin
          done <= 1'b1;
          st   <= P_IDLE;
        end else tick <= tick - 1'b1;
        default: st <= P_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/chain_wait_timer.sv
module chain_wait_timer #(
  parameter int CLK_HZ = 50_000_000,
  parameter int DEV_W  = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [1:0]       acq_sel,
  input  logic [1:0]       avg_sel,
  input  logic [DEV_W-1:0] slaves,
  output logic             done
);
  import chain_seq_pkg::*;

  localparam int CYC_US = (CLK_HZ / 1_000_000 < 1) ? 1 : CLK_HZ / 1_000_000;
  localparam int PW     = $clog2(CYC_US + 1);

  logic [31:0]   t_ns;
  logic [15:0]   us_need;
  logic [15:0]   us_left;
  logic [PW-1:0] pre;
  logic          run;

  always_comb begin
    t_ns    = ((32'(acq_ns(acq_sel)) + 32'd695) * 32'd12) << avg_sel;
    t_ns    = t_ns - 32'(acq_ns(acq_sel)) + 32'd250 * 32'(slaves);
    us_need = 16'((t_ns + 32'd999) / 32'd1000 + 32'd5);
  end

  always_ff @(posedge clk) begin
    done <= 1'b0;
    if (rst) begin
      run     <= 1'b0;
      us_left <= '0;
      pre     <= '0;
    end else if (start) begin
      run     <= 1'b1;
      us_left <= us_need;
      pre     <= PW'(CYC_US - 1);
    end else if (run) begin
      if (pre == '0) begin
        pre <= PW'(CYC_US - 1);
        if (us_left <= 16'd1) begin
          run  <= 1'b0;
          done <= 1'b1;
        end else us_left <= us_left - 1'b1;
      end else pre <= pre - 1'b1;
    end
  end
endmodule

// File: rtl/chain_seq.sv
module chain_seq #(
  parameter int CLK_HZ     = 50_000_000,
  parameter int SCLK_HALF  = 30,
  parameter int MAX_DEV    = 8,
  parameter int CH_PER_DEV = 12,
  parameter int CELLS      = 6,
  parameter int SUM_W      = 32
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       start,
  input  logic [1:0]                 acq_sel,
  input  logic [1:0]                 avg_sel,
  output logic                       busy,
  output logic                       done,
  output logic [$clog2(MAX_DEV)-1:0] slave_cnt,
  output logic                       frm_valid,
  output logic [31:0]                frm_data,
  output logic [SUM_W-1:0]           sum,
  output logic                       err_crc,
  output logic                       err_addr,
  output logic                       err_count,
  output logic [21:0]                crc_msg,
  input  logic [7:0]                 crc_val,
  output logic                       sclk,
  output logic                       mosi,
  input  logic                       miso,
  output logic                       cs_n
);
  import chain_seq_pkg::*;

  localparam int DEV_W = $clog2(MAX_DEV);
  localparam int IDX_W = $clog2(MAX_DEV * CH_PER_DEV + 1);

  seq_state_t       st;
  seq_mode_t        mode;
  logic             enum_pend;
  logic [1:0]       step, last_step;
  logic [IDX_W-1:0] idx, n_frames;
  logic [1:0]       acq_q, avg_q;
  logic [20:0]      hdr, hdr_q;
  logic [31:0]      rx_q;
  logic             phy_go, phy_done, tmr_go, tmr_done;
  logic [31:0]      phy_tx, phy_rx;

  assign n_frames  = IDX_W'((32'(slave_cnt) + 32'd1) * CH_PER_DEV);
  assign last_step = (mode == M_ENUM) ? 2'd2 : 2'd1;

  always_comb begin
    if (mode == M_ENUM) begin
      case (step)
        2'd0:    hdr = cmd_hdr(RA_CTL_LO, {1'b1, acq_q, 5'b10101});
        2'd1:    hdr = cmd_hdr(RA_CTL_LO, {1'b0, acq_q, 5'b10101});
        default: hdr = cmd_hdr(RA_RD_SEL, {RA_CTL_LO, 2'b00});
      endcase
    end else begin
      if (step == 2'd0) hdr = cmd_hdr(RA_RD_SEL, 8'h00);
      else              hdr = cmd_hdr(RA_CTL_HI, {4'b0000, 1'b1, avg_q, 1'b0});
    end
  end

  chain_spi_phy #(.HALF(SCLK_HALF)) u_phy (
    .clk(clk), .rst(rst), .start(phy_go), .tx_word(phy_tx), .miso(miso),
    .sclk(sclk), .mosi(mosi), .cs_n(cs_n), .done(phy_done), .rx_word(phy_rx)
  );

  chain_wait_timer #(.CLK_HZ(CLK_HZ), .DEV_W(DEV_W)) u_tmr (
    .clk(clk), .rst(rst), .start(tmr_go), .acq_sel(acq_q), .avg_sel(avg_q),
    .slaves(slave_cnt), .done(tmr_done)
  );

  always_ff @(posedge clk) begin
    phy_go    <= 1'b0;
    tmr_go    <= 1'b0;
    done      <= 1'b0;
    frm_valid <= 1'b0;
    if (rst) begin
      st        <= S_IDLE;
      mode      <= M_ENUM;
      enum_pend <= 1'b1;
      step      <= '0;
      idx       <= '0;
      acq_q     <= '0;
      avg_q     <= '0;
      hdr_q     <= '0;
      rx_q      <= '0;
      phy_tx    <= '0;
      busy      <= 1'b0;
      slave_cnt <= '0;
      frm_data  <= '0;
      sum       <= '0;
      err_crc   <= 1'b0;
      err_addr  <= 1'b0;
      err_count <= 1'b0;
      crc_msg   <= '0;
    end else begin
      case (st)
        S_IDLE: if (enum_pend || start) begin
          mode      <= enum_pend ? M_ENUM : M_SCAN;
          enum_pend <= 1'b0;
          if (!enum_pend) sum <= '0;
          busy      <= 1'b1;
          step      <= '0;
          idx       <= '0;
          acq_q     <= acq_sel;
          avg_q     <= avg_sel;
          err_crc   <= 1'b0;
          err_addr  <= 1'b0;
          err_count <= 1'b0;
          st        <= S_HDR;
        end
        S_HDR: begin
          crc_msg <= {1'b0, hdr};
          hdr_q   <= hdr;
          st      <= S_WLOAD;
        end
        S_WLOAD: begin
          phy_tx <= {hdr_q, crc_val, 3'b010};
          phy_go <= 1'b1;
          st     <= S_WXFER;
        end
        S_WXFER: if (phy_done) begin
          if (step == last_step) begin
            if (mode == M_SCAN) begin
              tmr_go <= 1'b1;
              st     <= S_DELAY;
            end else st <= S_POLL;
          end else begin
            step <= step + 1'b1;
            st   <= S_HDR;
          end
        end
        S_DELAY: if (tmr_done) st <= S_POLL;
        S_POLL: begin
          phy_tx <= POLL_WORD;
          phy_go <= 1'b1;
          st     <= S_RXFER;
        end
        S_RXFER: if (phy_done) begin
          rx_q    <= phy_rx;
          crc_msg <= phy_rx[31:10];
          st      <= S_EVAL;
        end
        S_EVAL: begin
          st <= S_POLL;
          if (mode == M_ENUM) begin
            if (rx_q == '0) begin
              if (idx == '0) err_count <= 1'b1;
              else slave_cnt <= DEV_W'(idx - 1'b1);
              st <= S_FIN;
            end else if (crc_val != rx_q[9:2]) begin
              err_crc <= 1'b1;
              st      <= S_FIN;
            end else if (IDX_W'(rev5(rx_q[31:27])) != idx) begin
              err_addr <= 1'b1;
              st       <= S_FIN;
            end else if (idx == IDX_W'(MAX_DEV)) begin
              err_count <= 1'b1;
              st        <= S_FIN;
            end else idx <= idx + 1'b1;
          end else begin
            if (crc_val != rx_q[9:2]) begin
              err_crc <= 1'b1;
              st      <= S_FIN;
            end else begin
              frm_valid <= 1'b1;
              frm_data  <= rx_q;
              if (rx_q[26:23] < 4'(CELLS)) sum <= sum + SUM_W'(rx_q[22:11]);
              if (idx == n_frames - 1'b1) st <= S_FIN;
              else idx <= idx + 1'b1;
            end
          end
        end
        S_FIN: begin
          done <= 1'b1;
          busy <= 1'b0;
          st   <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/chain_seq_chk.sv
module chain_seq_chk (
  input logic clk,
  input logic rst,
  input logic busy,
  input logic done,
  input logic frm_valid,
  input logic err_crc,
  input logic err_addr,
  input logic err_count,
  input logic sclk,
  input logic cs_n
);
  // R12
  sclk_idle_low_chk: assert property (@(posedge clk) disable iff (rst) cs_n |-> !sclk);
  // R12
  cs_idle_chk: assert property (@(posedge clk) disable iff (rst) !busy |-> cs_n);
  // R9
  frm_in_seq_chk: assert property (@(posedge clk) disable iff (rst) frm_valid |-> busy);
  // R9
  done_single_chk: assert property (@(posedge clk) disable iff (rst) done |=> !done);
  // R9
  done_idle_chk: assert property (@(posedge clk) disable iff (rst) done |-> !busy);
  // R11
  crc_abort_chk: assert property (@(posedge clk) disable iff (rst) $rose(err_crc) |=> done);
  // R4
  addr_abort_chk: assert property (@(posedge clk) disable iff (rst) $rose(err_addr) |=> done);
  // R5
  count_abort_chk: assert property (@(posedge clk) disable iff (rst) $rose(err_count) |=> done);
endmodule

bind chain_seq chain_seq_chk u_chk (
  .clk(clk), .rst(rst), .busy(busy), .done(done), .frm_valid(frm_valid),
  .err_crc(err_crc), .err_addr(err_addr), .err_count(err_count),
  .sclk(sclk), .cs_n(cs_n)
);

// File: tb/chain_seq_bench.sv
module chain_seq_bench;
  localparam int HALF   = 4;
  localparam int CLK_HZ = 50_000_000;
  localparam int CYC_US = 50;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0;
  logic [1:0] acq_sel = '0, avg_sel = '0;
  logic busy, done, frm_valid, err_crc, err_addr, err_count, sclk, mosi, cs_n;
  logic miso = 1'b0;
  logic [2:0] slave_cnt;
  logic [31:0] frm_data, sum;
  logic [21:0] crc_msg;
  logic [7:0] crc_val;

  always #10 clk = ~clk;

  chain_seq #(.CLK_HZ(CLK_HZ), .SCLK_HALF(HALF)) u_chain_seq (
    .clk(clk), .rst(rst), .start(start), .acq_sel(acq_sel), .avg_sel(avg_sel),
    .busy(busy), .done(done), .slave_cnt(slave_cnt), .frm_valid(frm_valid),
    .frm_data(frm_data), .sum(sum), .err_crc(err_crc), .err_addr(err_addr),
    .err_count(err_count), .crc_msg(crc_msg), .crc_val(crc_val),
    .sclk(sclk), .mosi(mosi), .miso(miso), .cs_n(cs_n)
  );

  function automatic logic [7:0] tab8(input logic [7:0] x);
    logic [7:0] c = x;
    for (int i = 0; i < 8; i++) c = c[7] ? ((c << 1) ^ 8'h2F) : (c << 1);
    return c;
  endfunction

  function automatic logic [7:0] crc8(input logic [23:0] v);
    logic [7:0] c;
    c = tab8(v[23:16]);
    c = tab8(c ^ v[15:8]);
    return c ^ v[7:0];
  endfunction

  always_comb crc_val = crc8({2'b00, crc_msg});

  function automatic logic [4:0] brev(input int n);
    logic [4:0] a = 5'(n), r;
    for (int i = 0; i < 5; i++) r[i] = a[4-i];
    return r;
  endfunction

  function automatic logic [31:0] wrf(input logic [5:0] ra, input logic [7:0] v);
    logic [31:0] r = {5'd0, ra, v, 1'b1, 12'd0};
    r[10:3] = crc8({3'b000, r[31:11]});
    r[1] = 1'b1;
    return r;
  endfunction

  function automatic logic [31:0] seal(input logic [31:0] f);
    logic [31:0] r = f;
    r[9:2] = crc8({2'b00, r[31:10]});
    return r;
  endfunction

  function automatic int wait_us(input int acq, input int avg, input int slaves);
    int t, ns;
    t  = (acq == 0) ? 465 : (acq == 1) ? 1010 : (acq == 2) ? 1460 : 1890;
    ns = (t + 695) * 12 * (1 << avg) - t + 250 * slaves;
    return (ns + 999) / 1000 + 5;
  endfunction

  // chain model
  logic [31:0] resp [0:255];
  logic [31:0] mlog [0:255];
  longint rise_t [0:255];
  longint fall_t [0:255];
  logic [31:0] got [0:255];
  int fcnt = 0, gcnt = 0;
  longint cyc = 0;
  logic [31:0] sh_out = '0, sh_in = '0;
  int nchk = 0, nerr = 0;

  always @(posedge clk) cyc++;
  always @(negedge cs_n) begin sh_out = resp[fcnt]; fall_t[fcnt] = cyc; end
  always @(posedge sclk) begin miso = sh_out[31]; sh_out = {sh_out[30:0], 1'b0}; end
  always @(negedge sclk) sh_in = {sh_in[30:0], mosi};
  always @(posedge cs_n) if (!rst) begin mlog[fcnt] = sh_in; rise_t[fcnt] = cyc; fcnt++; end
  always @(negedge clk) if (frm_valid) begin got[gcnt] = frm_data; gcnt++; end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_rng(input string req, input longint act, input longint lo, input longint hi);
    nchk++;
    if (act < lo || act > hi) begin
      nerr++;
      $display("FAIL %s: actual=%0d expected=%0d..%0d", req, act, lo, hi);
    end
  endtask

  task automatic wait_done();
    int n = 0;
    while (done !== 1'b1 && n < 60000) begin @(negedge clk); n++; end
    if (n >= 60000) chk("done timeout", 0, 1);
  endtask

  task automatic prep_enum(input int nvalid, input int bad_at);
    for (int i = 0; i < 3; i++) resp[i] = '0;
    for (int n = 0; n < nvalid; n++) begin
      logic [31:0] f = {brev(n), 17'($urandom), 10'd0};
      if (n == bad_at) f[31:27] = brev(n + 1);
      resp[3+n] = seal(f);
    end
    resp[3+nvalid] = '0;
  endtask

  task automatic run_enum(input int acq);
    acq_sel = 2'(acq);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    fcnt = 0; gcnt = 0;
    rst = 1'b0;
    wait_done();
  endtask

  task automatic run_scan(input int acq, input int avg, input int ndev, input int badk,
                          input bit poke);
    int nfr = ndev * 12, expn, bad;
    logic [31:0] esum = '0;
    for (int k = 0; k < nfr; k++) begin
      logic [31:0] f;
      int c = k % 12;
      f = {brev(k / 12), 4'(c), 12'($urandom), 11'd0};
      if (c >= 6) f[22:11] = 12'hF00 | 12'($urandom % 256);
      resp[2+k] = seal(f);
      if (k == badk) resp[2+k][2] = ~resp[2+k][2];
      if (c < 6 && (badk < 0 || k < badk)) esum += 32'(f[22:11]);
    end
    resp[0] = '0; resp[1] = '0;
    fcnt = 0; gcnt = 0;
    acq_sel = 2'(acq); avg_sel = 2'(avg);
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    if (poke) begin
      repeat (1500) @(negedge clk);
      start = 1'b1;
      @(negedge clk) start = 1'b0;
    end
    wait_done();
    expn = (badk < 0) ? nfr : badk;
    chk("R6 first scan write", mlog[0], wrf(6'h1C, 8'h00));
    chk("R6 second scan write", mlog[1], wrf(6'h0D, 8'h08 | 8'(avg << 1)));
    chk("R7 poll word", mlog[2 + expn - ((badk < 0) ? 1 : 0)], 32'hF800030A);
    chk("R9 frames emitted", gcnt, expn);
    chk("R9 frames polled", fcnt, 2 + ((badk < 0) ? nfr : badk + 1));
    bad = 0;
    for (int k = 0; k < expn; k++) if (got[k] !== resp[2+k]) bad++;
    chk("R9 frame data", bad, 0);
    chk("R10 cell sum", sum, esum);
    chk("R11 crc flag", err_crc, (badk >= 0));
    chk_rng("R8 conversion wait", fall_t[2] - rise_t[1],
            longint'(wait_us(acq, avg, ndev - 1) * CYC_US),
            longint'(wait_us(acq, avg, ndev - 1) * CYC_US + 2*HALF + 10));
    chk_rng("R12 cs gap", fall_t[3] - rise_t[2], 2*HALF, 1000);
    if (poke) begin
      repeat (40) @(negedge clk);
      chk("R13 start while busy", {busy, 8'(fcnt)}, {1'b0, 8'(2 + nfr)});
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 256; i++) resp[i] = '0;
    // R1 reset state
    prep_enum(2, -1);
    acq_sel = 2'd1;
    repeat (2) @(negedge clk);
    chk("R1 cs_n", cs_n, 1'b1);
    chk("R1 sclk", sclk, 1'b0);
    chk("R1 busy/done", {busy, done}, 2'b00);
    chk("R1 flags", {err_crc, err_addr, err_count}, 3'b000);
    chk("R1 count/sum", {slave_cnt, sum}, 35'd0);
    // enumeration of two devices
    run_enum(1);
    chk("R2 reset write", mlog[0], wrf(6'h0E, 8'hB5));
    chk("R2 release write", mlog[1], wrf(6'h0E, 8'h35));
    chk("R2 read select", mlog[2], wrf(6'h1C, 8'h38));
    chk("R7 enum polls", {mlog[3], mlog[5]}, {32'hF800030A, 32'hF800030A});
    chk("R3 slave count", slave_cnt, 3'd1);
    chk("R3 frames", fcnt, 6);
    chk("R3 no errors", {err_crc, err_addr, err_count}, 3'b000);
    // random scans
    for (int r = 0; r < 3; r++)
      run_scan(int'($urandom % 4), int'($urandom % 4), 2, -1, (r == 0));
    // R11 crc corruption mid-scan
    run_scan(2, 0, 2, 5, 1'b0);
    // R4 address mismatch
    prep_enum(3, 1);
    run_enum(0);
    chk("R4 addr flag", {err_addr, err_count}, 2'b10);
    chk("R4 frames", fcnt, 5);
    chk("R4 count untouched", slave_cnt, 3'd0);
    // R5 overlong chain
    prep_enum(9, -1);
    run_enum(3);
    chk("R5 overlong", {err_count, err_addr}, 2'b10);
    chk("R5 overlong frames", fcnt, 12);
    // R5 empty chain
    prep_enum(0, -1);
    run_enum(0);
    chk("R5 empty", err_count, 1'b1);
    // R3 full chain and full scan
    prep_enum(8, -1);
    run_enum(2);
    chk("R3 full chain", {slave_cnt, err_count}, {3'd7, 1'b0});
    run_scan(0, 0, 8, -1, 1'b0);
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule